// File: doc/BRIEF.md
# Multiplexed DRAM Strobe Decoder

This block is a synthesizable behavioural model of the control side of a single-bit-wide DRAM. The address lines are shared between row and column, and the block stores its bits in a small register array. It watches the active-low row strobe, the column strobe and the write enable. From the order in which these strobes fall, it decides what kind of cycle is running: a read, an early write, a delayed write (also called read-modify-write), a row-only refresh, or a refresh where the column strobe falls before the row strobe. All inputs are sampled on the system clock. A strobe edge is acted on at the first clock edge that sees the new level.

For refresh cycles where the column strobe leads, the block ignores the external address and uses its own refresh row counter. This counter wraps, so every row gets its turn. Each time a row is refreshed, the block raises a one-cycle pulse together with that row number, so a testbench can follow the refresh activity. Data-out is qualified by an output-enable. The enable stands in for the high-impedance state of a real pin.

Top module: `dram_strobe_ctl`

## Requirements
- R1: After reset, `dout_en`, `refresh_valid` and `cycle_kind` are 0, and the internal refresh counter is 0.
- R2: Read cycle. A row strobe fall with the column strobe high latches `addr` as the row. A later column strobe fall with `we_n` high latches `addr[COL_W-1:0]` as the column. From the clock edge that sees the column fall, `dout` equals the stored bit (same polarity as the bit written), `dout_en` is 1 and `cycle_kind` is 1.
- R3: `dout_en` stays 0 until the column strobe falls inside an open row cycle. It returns to 0 on the clock edge that sees the column strobe rise.
- R4: Early write. If `we_n` is low when the column strobe falls, `din` is stored at the selected row and column, `cycle_kind` becomes 2, and `dout_en` stays 0 for the whole cycle.
- R5: Delayed write. In a read cycle, a `we_n` fall while both strobes are low stores `din`, and `cycle_kind` becomes 3. `dout` keeps the value that was read and `dout_en` stays 1.
- R6: Every row strobe fall with the column strobe high gives a one-cycle `refresh_valid` pulse with `refresh_row` equal to `addr`, and sets `cycle_kind` to 4. If the column strobe never falls, `dout_en` stays 0.
- R7: A row strobe fall while the column strobe is already low is a counter refresh. `refresh_row` equals the internal counter, whatever `addr` holds. `cycle_kind` becomes 5 and the counter advances by one.
- R8: The refresh counter runs over 512 rows and wraps from 511 to 0.
- R9: Counter refreshes may be repeated by toggling only the row strobe while the column strobe stays low. Each fall refreshes the next row.
- R10: Hidden refresh. After a read, if the column strobe is held low while the row strobe is cycled, each fall is a counter refresh (R7), and `dout` and `dout_en` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ROW_W | Multiplexed row/column address |
| din | input | 1 | Write data |
| dout | output | 1 | Read data |
| dout_en | output | 1 | Output drive enable (0 = high impedance) |
| refresh_valid | output | 1 | One-cycle pulse when a row is refreshed |
| refresh_row | output | ROW_W | Row refreshed with the pulse |
| cycle_kind | output | 3 | Cycle class: 0 none, 1 read, 2 early write, 3 delayed write, 4 row-only, 5 counter refresh |

## Verification
The hardest case to reach is the counter wrap. It only shows up after the refresh counter has gone through all 512 rows. Before that run, the counter has also been advanced by the hidden refreshes done earlier. The bench keeps its own count of every counter refresh it causes. It then runs more than 512 back-to-back counter refreshes with the column strobe held low, changing `addr` on each one, so that the step from 511 to 0 is checked against that count. Hidden refresh is reached by holding the column strobe low after a read and toggling only the row strobe.

// File: rtl/dram_strobe_ctl.sv
module dram_strobe_ctl #(
  parameter int ROW_W    = 9,
  parameter int COL_W    = 2,
  parameter int REF_ROWS = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [ROW_W-1:0] addr,
  input  logic             din,
  output logic             dout,
  output logic             dout_en,
  output logic             refresh_valid,
  output logic [ROW_W-1:0] refresh_row,
  output logic [2:0]       cycle_kind
);
  localparam int ROWS = 1 << ROW_W;
  localparam int COLS = 1 << COL_W;
  localparam logic [ROW_W-1:0] LAST_REF = ROW_W'(REF_ROWS - 1);
  localparam logic [2:0] K_NONE = 3'd0, K_READ = 3'd1, K_EWR = 3'd2,
                         K_DWR = 3'd3, K_ROW = 3'd4, K_CBR = 3'd5;

  logic [COLS-1:0]  mem [ROWS];
  logic             ras_q, cas_q, we_q, row_open;
  logic [ROW_W-1:0] row, ref_cnt;
  logic [COL_W-1:0] col;

  wire ras_fall = ras_q & ~ras_n;
  wire ras_rise = ~ras_q & ras_n;
  wire cas_fall = cas_q & ~cas_n;
  wire cas_rise = ~cas_q & cas_n;
  wire we_fall  = we_q & ~we_n;
  wire [COL_W-1:0] acol = addr[COL_W-1:0];

  wire col_hit  = cas_fall & row_open & ~ras_n;
  wire ewr_en   = col_hit & ~we_n;
  wire dwr_en   = we_fall & ~cas_n & ~ras_n & row_open & ~col_hit & (cycle_kind == K_READ);
  wire wr_en    = ewr_en | dwr_en;
  wire [COL_W-1:0] wr_col = ewr_en ? acol : col;

  always_ff @(posedge clk)
    if (wr_en) mem[row][wr_col] <= din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1; cas_q <= 1'b1; we_q <= 1'b1;
      row_open <= 1'b0; row <= '0; col <= '0; ref_cnt <= '0;
      dout <= 1'b0; dout_en <= 1'b0; refresh_valid <= 1'b0;
      refresh_row <= '0; cycle_kind <= K_NONE;
    end else begin
      ras_q <= ras_n; cas_q <= cas_n; we_q <= we_n;
      refresh_valid <= 1'b0;
      if (ras_rise) row_open <= 1'b0;
      if (ras_fall) begin
        refresh_valid <= 1'b1;
        if (!cas_n) begin
          refresh_row <= ref_cnt;
          ref_cnt     <= (ref_cnt == LAST_REF) ? '0 : ref_cnt + 1'b1;
          cycle_kind  <= K_CBR;
          row_open    <= 1'b0;
        end else begin
          refresh_row <= addr;
          row         <= addr;
          row_open    <= 1'b1;
          cycle_kind  <= K_ROW;
        end
      end
      if (col_hit) begin
        col <= acol;
        if (!we_n) cycle_kind <= K_EWR;
        else begin
          dout       <= mem[row][acol];
          dout_en    <= 1'b1;
          cycle_kind <= K_READ;
        end
      end
      if (dwr_en) cycle_kind <= K_DWR;
      if (cas_rise) dout_en <= 1'b0;
    end
  end

  assert_hiz_until_cas_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> $past(!cas_n));
  assert_early_write_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_kind == K_EWR) |-> !dout_en);
  assert_delayed_write_keeps_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cycle_kind == K_DWR)) |-> (dout_en && $stable(dout)));
  assert_refresh_on_row_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_valid |-> $past(!ras_n));
  assert_counter_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cnt <= LAST_REF);
  assert_hidden_refresh_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && $past(dout_en)) |-> $stable(dout));
endmodule

// File: tb/sim_dram_strobe_ctl.sv
module sim_dram_strobe_ctl;
  localparam int ROW_W = 9, COL_W = 2, REF_ROWS = 512;
  logic clk = 0, rst_n = 0, ras_n = 1, cas_n = 1, we_n = 1, din = 0;
  logic [ROW_W-1:0] addr = '0;
  logic dout, dout_en, refresh_valid;
  logic [ROW_W-1:0] refresh_row;
  logic [2:0] cycle_kind;
  int checks = 0, fails = 0, exp_cnt = 0;
  bit model [512][4];

  always #5 clk = ~clk;

  dram_strobe_ctl #(.ROW_W(ROW_W), .COL_W(COL_W), .REF_ROWS(REF_ROWS)) u0 (
    .clk, .rst_n, .ras_n, .cas_n, .we_n, .addr, .din, .dout, .dout_en,
    .refresh_valid, .refresh_row, .cycle_kind);

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic open_row(input int r);
    addr = ROW_W'(r); ras_n = 0; tick;
    chk("R6 pulse", refresh_valid, 1); chk("R6 row", refresh_row, r);
    chk("R6 kind", cycle_kind, 4); chk("R3 no drive before cas", dout_en, 0);
  endtask

  task automatic close_all;
    we_n = 1; cas_n = 1; ras_n = 1; tick;
    chk("R3 release", dout_en, 0);
  endtask

  task automatic early_write(input int r, input int c, input bit d);
    open_row(r);
    addr = ROW_W'(c); we_n = 0; din = d; cas_n = 0; tick;
    chk("R4 kind", cycle_kind, 2); chk("R4 no drive", dout_en, 0);
    tick; chk("R4 still no drive", dout_en, 0);
    model[r][c] = d;
    close_all;
  endtask

  task automatic read_open(input int r, input int c);
    open_row(r);
    addr = ROW_W'(c); cas_n = 0; tick;
    chk("R2 kind", cycle_kind, 1); chk("R2 drive", dout_en, 1);
    chk("R2 data", dout, model[r][c]);
  endtask

  task automatic cbr_fall(input int junk);
    addr = ROW_W'(junk); ras_n = 0; tick;
    chk("R7 pulse", refresh_valid, 1); chk("R7 kind", cycle_kind, 5);
    chk("R7 R8 counter row", refresh_row, exp_cnt);
    exp_cnt = (exp_cnt + 1) % REF_ROWS;
    ras_n = 1; tick;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #12; tick;
    chk("R1 dout_en", dout_en, 0); chk("R1 pulse", refresh_valid, 0);
    chk("R1 kind", cycle_kind, 0);
    rst_n = 1; tick;

    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 4; c++) early_write(r * 61, c, bit'(((r + c) % 3) == 0));
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 4; c++) begin read_open(r * 61, c); close_all; end

    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        bit old;
        read_open(r * 61, c);
        old = model[r * 61][c];
        din = ~old; we_n = 0; tick;
        chk("R5 kind", cycle_kind, 3); chk("R5 drive", dout_en, 1);
        chk("R5 old data", dout, old);
        model[r * 61][c] = ~old;
        close_all;
        read_open(r * 61, c); close_all;
      end

    for (int r = 0; r < 3; r++) begin
      open_row(100 + r); tick; tick;
      chk("R6 row-only no drive", dout_en, 0);
      ras_n = 1; tick;
    end

    cas_n = 0; tick; chk("R3 cas without row", dout_en, 0);
    cbr_fall(77); cas_n = 1; tick;

    for (int k = 0; k < 2; k++) begin
      bit v;
      read_open(61, k);
      v = model[61][k];
      ras_n = 1; tick;
      chk("R10 drive kept", dout_en, 1); chk("R10 data kept", dout, v);
      for (int h = 0; h < 3; h++) begin
        cbr_fall(h * 5);
        chk("R10 drive", dout_en, 1); chk("R10 data", dout, v);
      end
      close_all;
    end

    cas_n = 0; tick;
    for (int i = 0; i < REF_ROWS + 4; i++) cbr_fall((i * 37) % 512);
    chk("R9 no drive across refreshes", dout_en, 0);
    cas_n = 1; tick;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule